// File: doc/BRIEF.md
# Punctured-Code Symbol Restorer

This block sits in front of a rate 1/2, constraint-length-7 Viterbi core. Its input is a stream of received soft decisions, one I/Q pair of 3-bit values per transfer, carrying a convolutional code from which some bits were removed at the transmitter. Its output is one (X,Y) pair for every trellis step. Each output symbol carries an erasure flag, and the flag is set wherever the transmitter dropped that bit. The decoder can then give erased positions zero weight in its branch metrics.

A rate code selects one of five periodic deletion patterns. The block walks the columns of the selected pattern. It draws symbols from the input only for the positions that were actually sent, and it fills the deleted positions with erasures. A synchronizer outside the block can slip the pattern framing by one column at a time with a single-cycle pulse, without resetting the block. Both sides use valid/ready handshakes, and the output is registered.

Top module: `dpnc_depuncturer`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, sets the pattern column to 0, selects rate code 0 and empties the symbol store. In the cycle after reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Rate codes 0 to 4 select rates 1/2, 2/3, 3/4, 5/6 and 7/8. Codes 5, 6 and 7 behave exactly like code 0.
- R3: Pattern column c of a rate keeps or erases X and Y as given by these keep strings, where character c (leftmost is column 0) is 1 for a sent bit. Rate 1/2: X 1, Y 1. Rate 2/3: X 10, Y 11. Rate 3/4: X 101, Y 110. Rate 5/6: X 10101, Y 11010. Rate 7/8: X 1000101, Y 1111010. Every column keeps at least one of the two symbols.
- R4: Sent symbols are taken in stream order: I then Q of each accepted input pair, then the next pair. Within one column X is served before Y. Every accepted input symbol appears exactly once at the output.
- R5: An erased output symbol has its flag at 1 and its data at 0. A kept symbol has its flag at 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, all output data and flags hold their values.
- R7: A one-cycle pulse on `phase_step` moves the pattern forward by one column, in addition to any advance from an emitted pair.
- R8: When `rate_sel` changes, the block emits nothing in the cycle the change is seen, and the next emitted pair uses column 0 of the new rate. Symbols already buffered are kept.
- R9: Each emitted pair advances the column by one. The column wraps to 0 after the last column of the pattern, which is 1, 2, 3, 5 or 7 columns long for the five rates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 3 | Rate code, 0..4 (5..7 act as 0) |
| phase_step | input | 1 | One-cycle pulse that slips the pattern by one column |
| in_valid | input | 1 | Input pair is valid |
| in_ready | output | 1 | Block can accept an input pair |
| in_i | input | SW | First soft symbol of the pair |
| in_q | input | SW | Second soft symbol of the pair |
| out_valid | output | 1 | Output pair is valid |
| out_ready | input | 1 | Downstream accepts the output pair |
| out_x | output | SW | X branch soft symbol (0 when erased) |
| out_y | output | SW | Y branch soft symbol (0 when erased) |
| out_x_erased | output | 1 | X position was deleted |
| out_y_erased | output | 1 | Y position was deleted |

## Verification
The hardest situations to reach from the ports are a framing slip or a rate change that lands while a lone leftover symbol is still buffered. The next column then has to take that symbol as its X or its Y, depending on the new framing. To get there, the bench stops input and drains the output until the store holds less than one column needs. It then issues the slip or the rate change and resumes streaming. Its own pattern model tracks the column and the stream index, so every later pair is checked symbol by symbol. Backpressure patterns that differ from table row to table row move the column at which stalls happen.

// File: rtl/dpnc_pkg.sv
package dpnc_pkg;

  localparam int MAX_COLS = 7;
  localparam int COL_W    = $clog2(MAX_COLS);

  typedef enum logic [2:0] {
    RATE_R12 = 3'd0,
    RATE_R23 = 3'd1,
    RATE_R34 = 3'd2,
    RATE_R56 = 3'd3,
    RATE_R78 = 3'd4
  } rate_e;

  // number of columns in the repeating deletion pattern
  function automatic logic [COL_W-1:0] cols_of(input logic [2:0] code);
    case (code)
      RATE_R23: cols_of = COL_W'(2);
      RATE_R34: cols_of = COL_W'(3);
      RATE_R56: cols_of = COL_W'(5);
      RATE_R78: cols_of = COL_W'(7);
      default:  cols_of = COL_W'(1);
    endcase
  endfunction

  // bit c set: X symbol of column c is sent
  function automatic logic [MAX_COLS-1:0] xkeep(input logic [2:0] code);
    case (code)
      RATE_R23: xkeep = 7'b0000001;
      RATE_R34: xkeep = 7'b0000101;
      RATE_R56: xkeep = 7'b0010101;
      RATE_R78: xkeep = 7'b1010001;
      default:  xkeep = 7'b0000001;
    endcase
  endfunction

  // bit c set: Y symbol of column c is sent
  function automatic logic [MAX_COLS-1:0] ykeep(input logic [2:0] code);
    case (code)
      RATE_R23: ykeep = 7'b0000011;
      RATE_R34: ykeep = 7'b0000011;
      RATE_R56: ykeep = 7'b0001011;
      RATE_R78: ykeep = 7'b0101111;
      default:  ykeep = 7'b0000001;
    endcase
  endfunction

endpackage

// File: rtl/dpnc_pattern.sv
module dpnc_pattern
  import dpnc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rate_sel,
  input  logic       advance,
  input  logic       nudge,
  output logic       settled,
  output logic       keep_x,
  output logic       keep_y
);

  logic [2:0]          rate_q;
  logic [COL_W-1:0]    col_q;
  logic [COL_W:0]      len;
  logic [COL_W:0]      sum0;
  logic [COL_W:0]      sum1;
  logic [COL_W:0]      sum2;
  logic [MAX_COLS-1:0] xm;
  logic [MAX_COLS-1:0] ym;

  always_comb begin
    settled = (rate_sel == rate_q);
    len     = {1'b0, cols_of(rate_q)};
    xm      = xkeep(rate_q);
    ym      = ykeep(rate_q);
    keep_x  = xm[col_q];
    keep_y  = ym[col_q];
    // up to two steps per cycle: emitted pair plus framing slip
    sum0    = {1'b0, col_q} + {{COL_W{1'b0}}, advance} + {{COL_W{1'b0}}, nudge};
    sum1    = (sum0 >= len) ? sum0 - len : sum0;
    sum2    = (sum1 >= len) ? sum1 - len : sum1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= RATE_R12;
      col_q  <= '0;
    end else if (!settled) begin
      rate_q <= rate_sel;
      col_q  <= '0;
    end else begin
      col_q  <= sum2[COL_W-1:0];
    end
  end

endmodule

// File: rtl/dpnc_symq.sv
module dpnc_symq #(
  parameter int SW    = 3,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [SW-1:0]    din_a,
  input  logic [SW-1:0]    din_b,
  input  logic [1:0]       pop,
  output logic [SW-1:0]    head_a,
  output logic [SW-1:0]    head_b,
  output logic [CNT_W-1:0] level
);

  logic [SW-1:0]    slot_q [DEPTH];
  logic [SW-1:0]    slot_n [DEPTH];
  logic [CNT_W-1:0] level_q;
  logic [CNT_W-1:0] rem;

  always_comb begin
    rem = level_q - CNT_W'(pop);
    for (int k = 0; k < DEPTH; k++) begin
      if (k + int'(pop) < DEPTH) slot_n[k] = slot_q[k + int'(pop)];
      else                       slot_n[k] = '0;
      if (push && (k == int'(rem)))     slot_n[k] = din_a;
      if (push && (k == int'(rem) + 1)) slot_n[k] = din_b;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot_q[g] <= '0;
      else     slot_q[g] <= slot_n[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= rem + (push ? CNT_W'(2) : CNT_W'(0));
  end

  assign head_a = slot_q[0];
  assign head_b = slot_q[1];
  assign level  = level_q;

endmodule

// File: rtl/dpnc_depuncturer.sv
module dpnc_depuncturer #(
  parameter int SW     = 3,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    rate_sel,
  input  logic          phase_step,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_i,
  input  logic [SW-1:0] in_q,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_x,
  output logic [SW-1:0] out_y,
  output logic          out_x_erased,
  output logic          out_y_erased
);

  localparam int CNT_W = $clog2(QDEPTH + 1);

  logic             settled;
  logic             keep_x;
  logic             keep_y;
  logic [1:0]       need;
  logic [1:0]       pop;
  logic [CNT_W-1:0] level;
  logic [SW-1:0]    head_a;
  logic [SW-1:0]    head_b;
  logic             take;
  logic             emit;

  dpnc_pattern pat_i (
    .clk      (clk),
    .rst      (rst),
    .rate_sel (rate_sel),
    .advance  (emit),
    .nudge    (phase_step),
    .settled  (settled),
    .keep_x   (keep_x),
    .keep_y   (keep_y)
  );

  dpnc_symq #(.SW(SW), .DEPTH(QDEPTH)) q_i (
    .clk    (clk),
    .rst    (rst),
    .push   (take),
    .din_a  (in_i),
    .din_b  (in_q),
    .pop    (pop),
    .head_a (head_a),
    .head_b (head_b),
    .level  (level)
  );

  always_comb begin
    need     = {1'b0, keep_x} + {1'b0, keep_y};
    in_ready = (level <= CNT_W'(QDEPTH - 2));
    take     = in_valid && in_ready;
    emit     = settled && (level >= CNT_W'(need)) && (!out_valid || out_ready);
    pop      = emit ? need : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_x        <= '0;
      out_y        <= '0;
      out_x_erased <= 1'b0;
      out_y_erased <= 1'b0;
    end else if (emit) begin
      out_valid    <= 1'b1;
      out_x        <= keep_x ? head_a : '0;
      out_y        <= keep_y ? (keep_x ? head_b : head_a) : '0;
      out_x_erased <= !keep_x;
      out_y_erased <= !keep_y;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

endmodule

// File: rtl/dpnc_depuncturer_chk.sv
module dpnc_depuncturer_chk #(
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] out_x,
  input logic [SW-1:0] out_y,
  input logic          out_x_erased,
  input logic          out_y_erased
);

  p_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));

  p_one_kept_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_x_erased && out_y_erased));

  p_x_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_x_erased) |-> (out_x == '0));

  p_y_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_y_erased) |-> (out_y == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)
                                   && $stable(out_x_erased) && $stable(out_y_erased)));

endmodule

bind dpnc_depuncturer dpnc_depuncturer_chk #(.SW(SW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_x        (out_x),
  .out_y        (out_y),
  .out_x_erased (out_x_erased),
  .out_y_erased (out_y_erased)
);

// File: tb/dpnc_depuncturer_tb_top.sv
module dpnc_depuncturer_tb_top;

  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    rate_sel = 3'd0;
  logic          phase_step = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [SW-1:0] in_i;
  logic [SW-1:0] in_q;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [SW-1:0] out_x;
  logic [SW-1:0] out_y;
  logic          out_x_erased;
  logic          out_y_erased;

  always #4 clk = ~clk;

  dpnc_depuncturer #(.SW(SW), .QDEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .phase_step(phase_step),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y(out_y),
    .out_x_erased(out_x_erased), .out_y_erased(out_y_erased)
  );

  // {rate code, outputs to check, ready pattern}
  localparam logic [14:0] VEC [9] = '{
    {3'd0, 8'd12, 4'b1111}, {3'd1, 8'd16, 4'b1111}, {3'd2, 8'd15, 4'b1101},
    {3'd3, 8'd20, 4'b1111}, {3'd4, 8'd21, 4'b1111}, {3'd4, 8'd14, 4'b0101},
    {3'd3, 8'd10, 4'b0111}, {3'd5, 8'd6,  4'b1111}, {3'd7, 8'd6,  4'b1010}
  };

  int total = 0;
  int fails = 0;
  int outs  = 0;
  int cyc   = 0;
  int pidx  = 0;
  int sidx  = 0;
  int mcol  = 0;
  logic [2:0] mrate = 3'd0;
  logic fire_pend = 1'b0;

  function automatic logic [SW-1:0] sym(input int k);
    return SW'((k % 7) + 1);
  endfunction

  function automatic int plen(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 5;
      3'd4: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic bit sent(input logic [2:0] c, input int col, input bit is_y);
    string s;
    case (c)
      3'd1: s = is_y ? "11" : "10";
      3'd2: s = is_y ? "110" : "101";
      3'd3: s = is_y ? "11010" : "10101";
      3'd4: s = is_y ? "1111010" : "1000101";
      default: s = "1";
    endcase
    return s[col] == 8'h31;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_out(input string tag);
    bit kx, ky;
    logic [SW-1:0] ex, ey;
    kx = sent(mrate, mcol, 1'b0);
    ky = sent(mrate, mcol, 1'b1);
    ex = '0;
    ey = '0;
    if (kx) begin ex = sym(sidx); sidx++; end
    if (ky) begin ey = sym(sidx); sidx++; end
    check({out_x, out_y, out_x_erased, out_y_erased} == {ex, ey, !kx, !ky}, tag,
          $sformatf("pair col %0d {x,y,xe,ye}", mcol),
          int'({out_x, out_y, out_x_erased, out_y_erased}), int'({ex, ey, !kx, !ky}));
    mcol = (mcol + 1) % plen(mrate);
    outs++;
  endtask

  task automatic tick(input logic v, input logic r, input logic ph, input string tag);
    @(negedge clk);
    if (fire_pend) begin
      pidx++;
      in_i = sym(2 * pidx);
      in_q = sym(2 * pidx + 1);
    end
    in_valid   = v;
    out_ready  = r;
    phase_step = ph;
    if (ph) mcol = (mcol + 1) % plen(mrate);
    if (out_valid && out_ready) check_out(tag);
    fire_pend = in_valid && in_ready;
    cyc++;
  endtask

  task automatic drain(input string tag);
    repeat (8) tick(1'b0, 1'b1, 1'b0, tag);
  endtask

  task automatic set_rate(input logic [2:0] code);
    if (code != rate_sel) mcol = 0;
    rate_sel = code;
    mrate    = code;
  endtask

  task automatic run(input int n, input logic [3:0] pat, input string tag);
    int goal;
    goal = outs + n;
    while (outs < goal) tick(1'b1, pat[cyc % 4], 1'b0, tag);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [2*SW+1:0] snap;
    in_i = sym(0);
    in_q = sym(1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state right after reset
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // table walk: R3 R4 R5 R9 for codes 0..4, R2 for codes 5..7
    for (int v = 0; v < 9; v++) begin
      drain("R4");
      set_rate(VEC[v][14:12]);
      run(int'(VEC[v][11:4]), VEC[v][3:0],
          (VEC[v][14:12] > 3'd4) ? "R2" : "R3/R4/R5/R9");
    end

    // R7: slip the framing with a buffered leftover at rate 7/8
    drain("R7");
    set_rate(3'd4);
    run(3, 4'b1111, "R7");
    drain("R7");
    tick(1'b0, 1'b1, 1'b1, "R7");
    run(16, 4'b1111, "R7");
    drain("R7");
    tick(1'b0, 1'b1, 1'b1, "R7");
    tick(1'b0, 1'b1, 1'b0, "R7");
    tick(1'b0, 1'b1, 1'b1, "R7");
    run(12, 4'b1011, "R7");

    // R8: rate change from a nonzero column keeps leftovers, restarts at column 0
    drain("R8");
    set_rate(3'd3);
    run(2, 4'b1111, "R8");
    drain("R8");
    set_rate(3'd2);
    run(8, 4'b1111, "R8");
    drain("R8");
    set_rate(3'd1);
    run(5, 4'b1111, "R8");

    // R6: output holds under backpressure
    drain("R6");
    set_rate(3'd3);
    repeat (4) tick(1'b1, 1'b0, 1'b0, "R6");
    check(out_valid == 1'b1, "R6", "out_valid while stalled", int'(out_valid), 1);
    snap = {out_x, out_y, out_x_erased, out_y_erased};
    repeat (3) begin
      tick(1'b1, 1'b0, 1'b0, "R6");
      check({out_x, out_y, out_x_erased, out_y_erased} == snap, "R6", "held pair",
            int'({out_x, out_y, out_x_erased, out_y_erased}), int'(snap));
    end
    run(10, 4'b1111, "R6");

    // R1: reset in mid-stream
    @(negedge clk);
    rst      = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after mid reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after mid reset", int'(in_ready), 1);
    rst       = 1'b0;
    rate_sel  = 3'd0;
    mrate     = 3'd0;
    mcol      = 0;
    pidx      = 0;
    sidx      = 0;
    fire_pend = 1'b0;
    in_i      = sym(0);
    in_q      = sym(1);
    set_rate(3'd2);
    run(9, 4'b1111, "R1");
    drain("R1");
    finish_up();
  end

endmodule